// File: doc/BRIEF.md
# Grouped GPIO Interrupt Controller

This block gathers interrupt requests from several groups of general-purpose input pins, with sixteen pins per group, and drives one combined interrupt line. Each pin passes through a two-stage synchroniser. A per-pin trigger mode then decides whether the pin raises a sticky pending bit. Four neighbouring pins share one 4-bit mode field.

Software uses a plain register port. Writes are single-cycle strobes and reads are combinational. Through this port software sets trigger modes and mask bits. It clears pending bits by writing ones to them. A service register names the highest-priority pending, unmasked source as a packed group and pin code. The usual handler loop reads the service register, handles the source it names, clears that pending bit, and repeats until the group field reads zero.

Two register groups share one 32-bit word of each register type. In the service code, group 1 is register group 0. Software may treat its pins 0 to 7 and 8 to 15 as two separate banks.

Top module: `gint_ctrl`

## Requirements
- R1: After reset, every mode field is 0, every mask bit is 1, every pending bit is 0, the service register reads 0 and `irq_o` is low.
- R2: Byte addresses decode as follows. Mode words start at 0x00, mask words at 0x20, pending words at 0x40, and the service register sits at 0x60. Register group g uses word base + 4×(g/2), bits 16×(g mod 2) to 16×(g mod 2)+15. Input `irq_in[16g+p]` is pin p of group g.
- R3: Within a 32-bit mode word, input bit i of that word (0..31) is governed by the 4-bit field at bit 4×(i/4). One write therefore sets the mode of four adjacent inputs.
- R4: Mode 1 (high level) and mode 0 (low level) set the pending bit on every clock while the synchronised input holds the active level. A bit cleared while the level is still active reads back set.
- R5: Mode 4 sets pending on a rising transition, mode 2 on a falling transition, and mode 6 on either. The opposite transition does not set the bit. A set bit stays set after the input returns.
- R6: Writing 1 to a pending bit clears it, unless an event arrives on the same clock, in which case the event wins. Writing 0 leaves the bit unchanged.
- R7: A mask bit of 1 keeps its source out of `irq_o` and out of the service register, but the pending bit still records events. Clearing the mask exposes an already-pending source.
- R8: The service register reads {24'b0, group+1 in bits 7:4, pin in bits 3:0}. It selects the lowest register group first, then the lowest pin within that group. It reads 0 when no source is both pending and unmasked.
- R9: `irq_o` is high exactly when some pending bit has its mask bit at 0.
- R10: The mode values 3, 5, 7 and 8 to 15 never set a pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_GROUPS*16 | Raw asynchronous interrupt pins, group-major |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte address of the read |
| rd_data | output | 32 | Combinational read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a clear that lands on the same clock as a new event. A level-mode input held active produces exactly that collision. The stimulus holds such an input high, writes the clear, and reads the bit straight back to confirm it is still set. Priority ordering is tested by leaving sources pending in two different groups, including one whose register group has the higher index. The service code must name the lower group first, and must move to the other source after the first is cleared.

// File: rtl/gint_pkg.sv
package gint_pkg;
  localparam int GRP_PINS = 16;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;

  typedef enum logic [3:0] {
    TRIG_LOW  = 4'd0,
    TRIG_HIGH = 4'd1,
    TRIG_FALL = 4'd2,
    TRIG_RISE = 4'd4,
    TRIG_BOTH = 4'd6
  } trig_e;

  // register type select, taken from address bits 6:5
  localparam logic [1:0] SEL_CFG  = 2'd0;
  localparam logic [1:0] SEL_MASK = 2'd1;
  localparam logic [1:0] SEL_PEND = 2'd2;
  localparam logic [1:0] SEL_SVC  = 2'd3;
endpackage

// File: rtl/gint_group.sv
module gint_group
  import gint_pkg::*;
#(
  parameter int PINS = GRP_PINS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_i,
  input  logic [PINS-1:0] cfg_i,
  input  logic [PINS-1:0] clr_i,
  output logic [PINS-1:0] pend_o
);
  logic [PINS-1:0] s1_q, s2_q, s3_q;
  logic [PINS-1:0] ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    localparam int FLD = 4 * (p / 4);
    logic [3:0] code;
    assign code = cfg_i[FLD +: 4];
    always_comb begin
      case (code)
        TRIG_LOW:  ev[p] = ~s2_q[p];
        TRIG_HIGH: ev[p] = s2_q[p];
        TRIG_FALL: ev[p] = s3_q[p] & ~s2_q[p];
        TRIG_RISE: ev[p] = ~s3_q[p] & s2_q[p];
        TRIG_BOTH: ev[p] = s3_q[p] ^ s2_q[p];
        default:   ev[p] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= '0;
    else        pend_o <= (pend_o & ~clr_i) | ev;
  end
endmodule

// File: rtl/gint_svc_enc.sv
module gint_svc_enc
  import gint_pkg::*;
#(
  parameter int NUM_GROUPS = 4
) (
  input  logic [NUM_GROUPS*GRP_PINS-1:0] act_i,
  output logic [7:0]                     svc_o
);
  logic found;

  always_comb begin
    svc_o = '0;
    found = 1'b0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      for (int p = 0; p < GRP_PINS; p++) begin
        if (!found && act_i[g*GRP_PINS+p]) begin
          svc_o = {4'(g + 1), 4'(p)};
          found = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/gint_ctrl.sv
module gint_ctrl
  import gint_pkg::*;
#(
  parameter int NUM_GROUPS = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_GROUPS*GRP_PINS-1:0] irq_in,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic [ADDR_W-1:0]              rd_addr,
  output logic [DATA_W-1:0]              rd_data,
  output logic                           irq_o
);
  localparam int NBITS = NUM_GROUPS * GRP_PINS;

  logic       w_ok, r_ok;
  logic [1:0] w_sel, r_sel;
  logic [2:0] w_word, r_word;

  assign w_ok   = wr_en && (wr_addr[ADDR_W-1:7] == '0) && (wr_addr[1:0] == 2'b00);
  assign w_sel  = wr_addr[6:5];
  assign w_word = wr_addr[4:2];
  assign r_ok   = (rd_addr[ADDR_W-1:7] == '0) && (rd_addr[1:0] == 2'b00);
  assign r_sel  = rd_addr[6:5];
  assign r_word = rd_addr[4:2];

  logic [GRP_PINS-1:0] cfg_q  [NUM_GROUPS];
  logic [GRP_PINS-1:0] mask_q [NUM_GROUPS];
  logic [GRP_PINS-1:0] pend_g [NUM_GROUPS];
  logic [NBITS-1:0]    pend_flat, mask_flat, clr_flat, act;
  logic [7:0]          svc_code;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam logic [2:0] WORD = 3'(g / 2);
    localparam int         LSB  = GRP_PINS * (g % 2);
    logic                hit;
    logic [GRP_PINS-1:0] slice;
    assign hit   = w_ok && (w_word == WORD);
    assign slice = wr_data[LSB +: GRP_PINS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[g]  <= '0;
        mask_q[g] <= '1;
      end else begin
        if (hit && w_sel == SEL_CFG)  cfg_q[g]  <= slice;
        if (hit && w_sel == SEL_MASK) mask_q[g] <= slice;
      end
    end

    assign clr_flat[g*GRP_PINS +: GRP_PINS] = (hit && w_sel == SEL_PEND) ? slice : '0;

    gint_group #(.PINS(GRP_PINS)) u_grp (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (irq_in[g*GRP_PINS +: GRP_PINS]),
      .cfg_i  (cfg_q[g]),
      .clr_i  (clr_flat[g*GRP_PINS +: GRP_PINS]),
      .pend_o (pend_g[g])
    );

    assign pend_flat[g*GRP_PINS +: GRP_PINS] = pend_g[g];
    assign mask_flat[g*GRP_PINS +: GRP_PINS] = mask_q[g];
  end

  assign act = pend_flat & ~mask_flat;

  gint_svc_enc #(.NUM_GROUPS(NUM_GROUPS)) u_enc (
    .act_i (act),
    .svc_o (svc_code)
  );

  assign irq_o = |act;

  always_comb begin
    rd_data = '0;
    if (r_ok) begin
      if (r_sel == SEL_SVC) begin
        if (r_word == 3'd0) rd_data = {{(DATA_W-8){1'b0}}, svc_code};
      end else begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
          if (r_word == 3'(g / 2)) begin
            case (r_sel)
              SEL_CFG:  rd_data[GRP_PINS*(g%2) +: GRP_PINS] = cfg_q[g];
              SEL_MASK: rd_data[GRP_PINS*(g%2) +: GRP_PINS] = mask_q[g];
              default:  rd_data[GRP_PINS*(g%2) +: GRP_PINS] = pend_g[g];
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/gint_ctrl_chk.sv
module gint_ctrl_chk
  import gint_pkg::*;
#(
  parameter int NUM_GROUPS = 4
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [NUM_GROUPS*GRP_PINS-1:0] pend_flat,
  input logic [NUM_GROUPS*GRP_PINS-1:0] mask_flat,
  input logic [NUM_GROUPS*GRP_PINS-1:0] clr_flat,
  input logic [7:0]                     svc_code,
  input logic                           irq_o
);
  int unsigned svc_idx;
  always_comb svc_idx = (int'(svc_code[7:4]) - 1) * GRP_PINS + int'(svc_code[3:0]);

  // R9: combined line follows the encoder's "something found" state
  a_r9_irq_vs_svc: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (svc_code[7:4] != 4'd0));

  // R8: a reported source is pending and unmasked
  a_r8_svc_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_code[7:4] != 4'd0) |-> (pend_flat[svc_idx] && !mask_flat[svc_idx]));

  // R7: everything masked keeps the line low
  a_r7_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_flat) |-> !irq_o);

  // R6: a pending bit only drops after a write-1 clear
  a_r6_sticky_pend: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pend_flat) & ~$past(clr_flat)) & ~pend_flat) == '0));
endmodule

bind gint_ctrl gint_ctrl_chk #(.NUM_GROUPS(NUM_GROUPS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pend_flat (pend_flat),
  .mask_flat (mask_flat),
  .clr_flat  (clr_flat),
  .svc_code  (svc_code),
  .irq_o     (irq_o)
);

// File: tb/tb_gint_ctrl.sv
`timescale 1ns/1ps
module tb_gint_ctrl;
  localparam int NG = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NG*16-1:0] irq_in = '0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [7:0]    rd_addr = '0;
  logic [31:0]   rd_data;
  logic          irq_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] cfg0, cfg1;

  always #5 clk = ~clk;

  gint_ctrl #(.NUM_GROUPS(NG)) dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_o(irq_o)
  );

  localparam logic [7:0] A_CFG = 8'h00, A_MASK = 8'h20, A_PEND = 8'h40, A_SVC = 8'h60;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin(input int i, input logic v);
    @(negedge clk);
    irq_in[i] = v;
    idle(5);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_CFG, d);        chk("R1 cfg0", d, 32'h0);
    rd(A_CFG + 4, d);    chk("R1 cfg1", d, 32'h0);
    rd(A_MASK, d);       chk("R1 mask0", d, 32'hffff_ffff);
    rd(A_MASK + 4, d);   chk("R1 mask1", d, 32'hffff_ffff);
    rd(A_PEND, d);       chk("R1 pend0", d, 32'h0);
    rd(A_SVC, d);        chk("R1 svc", d, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_setup();
    logic [31:0] d;
    cfg0 = 32'h4444_4444; cfg1 = 32'h4444_4444;
    wr(A_CFG, cfg0); wr(A_CFG + 4, cfg1);
    idle(4);
    wr(A_PEND, 32'hffff_ffff); wr(A_PEND + 4, 32'hffff_ffff);
    idle(4);
    rd(A_PEND, d);     chk("R6 pend0 cleared", d, 32'h0);
    rd(A_PEND + 4, d); chk("R6 pend1 cleared", d, 32'h0);
  endtask

  task automatic t_rise_mask_clear();
    logic [31:0] d;
    pin(5, 1'b1);
    rd(A_PEND, d); chk("R5 rise sets pend", d, 32'h0000_0020);
    chk("R7 masked irq low", {31'b0, irq_o}, 32'h0);
    rd(A_SVC, d);  chk("R7 masked svc zero", d, 32'h0);
    wr(A_MASK, 32'hffff_ffdf);
    #1 chk("R9 irq after unmask", {31'b0, irq_o}, 32'h1);
    rd(A_SVC, d);  chk("R8 svc group1 pin5", d, 32'h15);
    pin(5, 1'b0);
    rd(A_PEND, d); chk("R5 sticky after fall", d, 32'h0000_0020);
    wr(A_PEND, 32'h0);
    rd(A_PEND, d); chk("R6 write 0 no effect", d, 32'h0000_0020);
    wr(A_PEND, 32'h0000_0020);
    rd(A_PEND, d); chk("R6 write 1 clears", d, 32'h0);
    chk("R9 irq low after clear", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_fall_shared();
    logic [31:0] d;
    wr(A_MASK, 32'hffff_0000);
    cfg0 = 32'h4444_4424;  // pins 4..7 falling via field at bit 4
    wr(A_CFG, cfg0);
    pin(6, 1'b1);
    rd(A_PEND, d); chk("R5 rise ignored in fall mode", d, 32'h0);
    pin(6, 1'b0);
    rd(A_PEND, d); chk("R3 fall sets pin6", d, 32'h0000_0040);
    pin(7, 1'b1); pin(7, 1'b0);
    rd(A_PEND, d); chk("R3 shared field pin7", d, 32'h0000_00c0);
    pin(3, 1'b1); pin(3, 1'b0);
    rd(A_PEND, d); chk("R3 neighbour field rising pin3", d, 32'h0000_00c8);
    wr(A_PEND, 32'h0000_0088);
    rd(A_SVC, d);  chk("R8 svc pin6", d, 32'h16);
  endtask

  task automatic t_both_priority();
    logic [31:0] d;
    cfg0 = 32'h4464_4424;  // word bit 20 field -> group 1 pins 4..7 both edges
    wr(A_CFG, cfg0);
    wr(A_MASK, 32'hffef_0000);
    pin(20, 1'b1);
    rd(A_PEND, d); chk("R2 group1 pin4 at bit20", d, 32'h0010_0040);
    rd(A_SVC, d);  chk("R8 lower group wins", d, 32'h16);
    wr(A_PEND, 32'h0010_0040);
    pin(20, 1'b0);
    rd(A_PEND, d); chk("R5 both-edge fall", d, 32'h0010_0000);
    rd(A_SVC, d);  chk("R8 svc group2 pin4", d, 32'h24);
    wr(A_PEND, 32'h0010_0000);
  endtask

  task automatic t_level();
    logic [31:0] d;
    cfg1 = 32'h4444_4441;  // group 2 pins 0..3 high level
    wr(A_CFG + 4, cfg1);
    wr(A_MASK + 4, 32'h0000_0000);
    pin(33, 1'b1);
    rd(A_PEND + 4, d); chk("R4 high level pends", d, 32'h0000_0002);
    wr(A_PEND + 4, 32'h0000_0002);
    rd(A_PEND + 4, d); chk("R4 clear while active re-pends", d, 32'h0000_0002);
    pin(33, 1'b0);
    wr(A_PEND + 4, 32'h0000_0002);
    idle(3);
    rd(A_PEND + 4, d); chk("R4 clear after level drop", d, 32'h0);
    cfg1 = 32'h4044_4441;  // group 3 pins 8..11 low level (word bit 24)
    wr(A_CFG + 4, cfg1);
    idle(2);
    rd(A_PEND + 4, d); chk("R4 low level pends", d, 32'h0f00_0000);
    for (int i = 56; i < 60; i++) irq_in[i] = 1'b1;
    idle(5);
    wr(A_PEND + 4, 32'h0f00_0000);
    rd(A_PEND + 4, d); chk("R4 low level released clears", d, 32'h0);
  endtask

  task automatic t_invalid();
    logic [31:0] d;
    cfg1 = 32'h3044_4441;  // group 3 pins 12..15 code 3
    wr(A_CFG + 4, cfg1);
    pin(61, 1'b1); pin(61, 1'b0);
    rd(A_PEND + 4, d); chk("R10 code 3 no pend", d, 32'h0);
    cfg1 = 32'h9044_4441;
    wr(A_CFG + 4, cfg1);
    pin(62, 1'b1); pin(62, 1'b0);
    rd(A_PEND + 4, d); chk("R10 code 9 no pend", d, 32'h0);
  endtask

  task automatic t_cross_group();
    logic [31:0] d;
    cfg1 = 32'h9044_4441;
    pin(41, 1'b1);   // group 2 pin 9 rising
    pin(50, 1'b1);   // group 3 pin 2 rising
    rd(A_PEND + 4, d); chk("R2 word1 bits", d, 32'h0004_0200);
    rd(A_SVC, d);      chk("R8 group3 before group4", d, 32'h39);
    wr(A_PEND + 4, 32'h0000_0200);
    rd(A_SVC, d);      chk("R8 then group4 pin2", d, 32'h42);
    wr(A_MASK + 4, 32'h0004_0000);
    #1 chk("R7 masking last source drops irq", {31'b0, irq_o}, 32'h0);
    rd(A_PEND + 4, d); chk("R7 masked still pending", d, 32'h0004_0000);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    t_reset();
    t_setup();
    t_rise_mask_clear();
    t_fall_shared();
    t_both_priority();
    t_level();
    t_invalid();
    t_cross_group();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule